// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. A shared main counter lives outside the channel and is fed in together with a strobe that marks each counter increment. The channel holds a comparator value, a reload period and a small configuration word. On an increment where the counter has reached the comparator, it emits a one-cycle fire strobe toward the interrupt logic.

In one-shot mode the channel fires once and then stays quiet until it is armed again. In periodic mode each fire advances the comparator by the stored period. If the counter is already past the new value, the channel keeps adding the period, one addition per clock, until the comparator is ahead again. It issues no extra fire while doing so. A narrow mode limits the comparator, the period and the match test to the low half of the counter. In narrow one-shot mode the channel also fires when the low half of the counter rolls over to zero.

Software reaches the channel through 32-bit writes to three locations: the configuration word, the low half of the comparator and the high half of the comparator. In periodic mode a comparator write normally loads the period. The comparator itself changes only when the direct-set bit has been armed first.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all-ones, the period reads zero, the fire output is low and the configuration reads 0x30: bit 4 (periodic capable) and bit 5 (wide capable) set, all writable bits clear.
- R2: In one-shot mode, on an increment strobe where the counter is at or past the comparator (the signed difference comparator minus counter is not positive), fire_o goes high for exactly one cycle in the following cycle. The channel then stays quiet until it is armed again by an enable rise or a comparator write while enabled.
- R3: In periodic mode with a non-zero period, each fire adds the period to the comparator. While the comparator is still not ahead of the counter, one more period is added per clock and no fire is issued.
- R4: A comparator write (select 1 = low half, 2 = high half) changes the comparator only in one-shot mode or when the direct-set bit (configuration bit 2) is 1. Any comparator write clears the direct-set bit.
- R5: In periodic mode a low-half write loads the period's low half, with bit 31 forced to 0 in narrow mode. A high-half write without direct-set loads the period's high half with bit 63 forced to 0.
- R6: Writing the configuration (select 0) with the narrow bit (bit 3) set clears the upper 32 bits of the comparator and the period at once. In narrow mode the match test uses a 32-bit signed difference, and high-half comparator writes change nothing.
- R7: In narrow one-shot mode, if arming finds the low counter half above the comparator, the channel first fires on the increment where the low half becomes zero, and then fires again at the comparator match.
- R8: A 0-to-1 change of the enable bit (bit 0) arms the channel. A 1-to-0 change disarms it, and the channel does not fire while it is disabled. The periodic bit is bit 1.
- R9: While global_en_i is low the channel neither fires nor advances. An armed channel whose match has passed fires on the first increment after global_en_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Shared main counter value |
| tick_i | input | 1 | Counter incremented; evaluate match this cycle |
| global_en_i | input | 1 | Timer block global enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 comparator low, 2 comparator high |
| wr_data_i | input | 32 | Write data |
| cfg_o | output | 32 | Configuration word readback |
| cmp_o | output | 64 | Comparator readback |
| period_o | output | 64 | Period readback |
| fire_o | output | 1 | One-cycle fire strobe |

## Verification
The match logic is driven with a counter that starts below the comparator, one that starts well past it, and one that sits just below the rollover of its low half. The first tells exact-match timing from early or late firing. The second tells a single catch-up fire from a burst of repeated fires. The third separates the rollover fire from the real match. Periodic runs compare the sequence of fire positions and the final comparator against the period arithmetic. Gated runs, with the channel disabled or the global enable low, show whether a passed match is lost, suppressed or delivered once the gate opens.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_CMP_LO = 2'd1,
        SEL_CMP_HI = 2'd2,
        SEL_NONE   = 2'd3
    } wsel_e;

    localparam int CFG_EN     = 0;
    localparam int CFG_PER    = 1;
    localparam int CFG_SET    = 2;
    localparam int CFG_NARROW = 3;
    localparam int CFG_PCAP   = 4;
    localparam int CFG_WCAP   = 5;
endpackage

// File: rtl/evt_ahead.sv
module evt_ahead #(
    parameter int W = 64,
    localparam int H = W / 2
) (
    input  logic [W-1:0] lead_i,
    input  logic [W-1:0] base_i,
    input  logic         narrow_i,
    output logic         ahead_o
);
    logic [W-1:0] diff;
    logic [H-1:0] diff_lo;

    assign diff    = lead_i - base_i;
    assign diff_lo = diff[H-1:0];
    assign ahead_o = narrow_i ? ($signed(diff_lo) > 0) : ($signed(diff) > 0);
endmodule

// File: rtl/evt_wrap_arm.sv
module evt_wrap_arm #(
    parameter int W = 64,
    localparam int H = W / 2
) (
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] count_i,
    input  logic         narrow_i,
    input  logic         periodic_i,
    output logic         wrap_o
);
    logic lo_ahead;

    evt_ahead #(.W(W)) u_lo_ahead (
        .lead_i  (cmp_i),
        .base_i  (count_i),
        .narrow_i(1'b1),
        .ahead_o (lo_ahead)
    );

    // Rollover comes first when the target is ahead but numerically below the counter.
    assign wrap_o = narrow_i && !periodic_i && lo_ahead && (cmp_i[H-1:0] < count_i[H-1:0]);
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             tick_i,
    input  logic             global_en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [HALF-1:0]  wr_data_i,
    output logic [HALF-1:0]  cfg_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] period_o,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    typedef struct packed {
        logic             en;
        logic             per;
        logic             setv;
        logic             narrow;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] period;
    } regs_t;

    typedef struct packed {
        regs_t r;
        logic  armed;
        logic  wrap;
        logic  catchup;
        logic  fire;
    } st_t;

    st_t              st_q, st_d;
    regs_t            wr_d;
    logic             arm_ev, disarm_ev;
    logic             cmp_ahead, wrap_arm, live;
    logic [CNT_W-1:0] step_sum, step_cmp;
    wsel_e            sel;

    assign sel = wsel_e'(wr_sel_i);

    evt_ahead #(.W(CNT_W)) u_match (
        .lead_i  (st_q.r.cmp),
        .base_i  (count_i),
        .narrow_i(st_q.r.narrow),
        .ahead_o (cmp_ahead)
    );

    evt_wrap_arm #(.W(CNT_W)) u_wrap (
        .cmp_i     (wr_d.cmp),
        .count_i   (count_i),
        .narrow_i  (wr_d.narrow),
        .periodic_i(wr_d.per),
        .wrap_o    (wrap_arm)
    );

    assign step_sum = st_q.r.cmp + st_q.r.period;
    assign step_cmp = st_q.r.narrow ? (step_sum & LO_MASK) : step_sum;

    // Register write decode: new register image plus arm/disarm events.
    always_comb begin
        wr_d      = st_q.r;
        arm_ev    = 1'b0;
        disarm_ev = 1'b0;
        if (wr_en_i) begin
            case (sel)
                SEL_CFG: begin
                    wr_d.en     = wr_data_i[CFG_EN];
                    wr_d.per    = wr_data_i[CFG_PER];
                    wr_d.setv   = wr_data_i[CFG_SET];
                    wr_d.narrow = wr_data_i[CFG_NARROW];
                    if (wr_data_i[CFG_NARROW]) begin
                        wr_d.cmp    = st_q.r.cmp & LO_MASK;
                        wr_d.period = st_q.r.period & LO_MASK;
                    end
                    arm_ev    = !st_q.r.en && wr_data_i[CFG_EN];
                    disarm_ev = st_q.r.en && !wr_data_i[CFG_EN];
                end
                SEL_CMP_LO: begin
                    if (!st_q.r.per || st_q.r.setv)
                        wr_d.cmp[HALF-1:0] = wr_data_i;
                    if (st_q.r.per)
                        wr_d.period[HALF-1:0] = st_q.r.narrow ?
                            {1'b0, wr_data_i[HALF-2:0]} : wr_data_i;
                    wr_d.setv = 1'b0;
                    arm_ev    = st_q.r.en;
                end
                SEL_CMP_HI: begin
                    if (!st_q.r.narrow) begin
                        if (!st_q.r.per || st_q.r.setv)
                            wr_d.cmp[CNT_W-1:HALF] = wr_data_i;
                        else
                            wr_d.period[CNT_W-1:HALF] = {1'b0, wr_data_i[HALF-2:0]};
                    end
                    wr_d.setv = 1'b0;
                    arm_ev    = st_q.r.en;
                end
                default: ;
            endcase
        end
    end

    assign live = !wr_en_i && st_q.armed && st_q.r.en && global_en_i;

    // Next-state: arming, match, periodic catch-up, rollover fire.
    always_comb begin
        st_d      = st_q;
        st_d.r    = wr_d;
        st_d.fire = 1'b0;
        if (arm_ev) begin
            st_d.armed   = 1'b1;
            st_d.catchup = 1'b0;
            st_d.wrap    = wrap_arm;
        end else if (disarm_ev) begin
            st_d.armed   = 1'b0;
            st_d.catchup = 1'b0;
            st_d.wrap    = 1'b0;
        end else if (live) begin
            if (st_q.catchup) begin
                if (cmp_ahead) st_d.catchup = 1'b0;
                else           st_d.r.cmp   = step_cmp;
            end else if (tick_i) begin
                if (st_q.wrap) begin
                    if (count_i[HALF-1:0] == '0) begin
                        st_d.fire = 1'b1;
                        st_d.wrap = 1'b0;
                    end
                end else if (!cmp_ahead) begin
                    st_d.fire = 1'b1;
                    if (st_q.r.per && (st_q.r.period != '0)) begin
                        st_d.r.cmp   = step_cmp;
                        st_d.catchup = 1'b1;
                    end else begin
                        st_d.armed = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.r.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_o             = '0;
        cfg_o[CFG_EN]     = st_q.r.en;
        cfg_o[CFG_PER]    = st_q.r.per;
        cfg_o[CFG_SET]    = st_q.r.setv;
        cfg_o[CFG_NARROW] = st_q.r.narrow;
        cfg_o[CFG_PCAP]   = 1'b1;
        cfg_o[CFG_WCAP]   = 1'b1;
    end

    assign cmp_o    = st_q.r.cmp;
    assign period_o = st_q.r.period;
    assign fire_o   = st_q.fire;

    assert_fire_needs_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(global_en_i));

    assert_narrow_cmp_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[CFG_NARROW] |-> (cmp_o[CNT_W-1:HALF] == '0));

    assert_period_top_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_o[CNT_W-1]);

    assert_setval_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (sel == SEL_CMP_LO || sel == SEL_CMP_HI)) |=> !cfg_o[CFG_SET]);

    assert_disable_no_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel == SEL_CFG && !wr_data_i[CFG_EN]) |=> !fire_o);
endmodule

// File: tb/test_evt_cmp_channel.sv
module test_evt_cmp_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        tick_i = 1'b0;
    logic        global_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] cfg_o;
    logic [63:0] cmp_o, period_o;
    logic        fire_o;

    int checks = 0;
    int errors = 0;
    int fires = 0;
    logic [63:0] fire_at [0:7];
    bit done = 1'b0;

    evt_cmp_channel i_evt_cmp_channel (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .tick_i(tick_i),
        .global_en_i(global_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cfg_o(cfg_o), .cmp_o(cmp_o),
        .period_o(period_o), .fire_o(fire_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; global_en_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        fires = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(posedge clk);
            #1;
            if (fire_o) begin
                if (fires < 8) fire_at[fires] = count_i;
                fires++;
            end
            count_i = count_i + 64'd1;
        end
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (fire_o) fires++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(posedge clk); #1;
        check("R1 cfg reset", {32'd0, cfg_o}, 64'h30);
        check("R1 cmp reset", cmp_o, '1);
        check("R1 period reset", period_o, 64'd0);
        check("R1 fire reset", {63'd0, fire_o}, 64'd0);
    endtask

    task automatic t_oneshot();
        do_reset();
        count_i = 64'd95;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h1);
        run_ticks(30);
        check("R2 one fire", fires, 1);
        check("R2 fire at match", fire_at[0], 64'd100);
        fires = 0;
        wr(2'd1, 32'd130);
        run_ticks(10);
        check("R2 rearm fire count", fires, 1);
        check("R2 rearm fire at", fire_at[0], 64'd130);
    endtask

    task automatic t_periodic();
        do_reset();
        count_i = 64'd190;
        wr(2'd0, 32'h6);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h6);
        wr(2'd1, 32'd200);
        check("R4 setval cleared", {32'd0, cfg_o}, 64'h32);
        wr(2'd1, 32'd50);
        check("R4 cmp kept without setval", cmp_o, 64'd200);
        check("R5 period loaded", period_o, 64'd50);
        wr(2'd0, 32'h3);
        run_ticks(120);
        check("R3 periodic fire count", fires, 3);
        check("R3 first", fire_at[0], 64'd200);
        check("R3 second", fire_at[1], 64'd250);
        check("R3 third", fire_at[2], 64'd300);
        check("R3 cmp advanced", cmp_o, 64'd350);
    endtask

    task automatic t_catchup();
        do_reset();
        count_i = 64'd135;
        wr(2'd0, 32'h6);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h6);
        wr(2'd1, 32'd100);
        wr(2'd1, 32'd10);
        wr(2'd0, 32'h3);
        run_ticks(1);
        idle(6);
        check("R3 catch-up single fire", fires, 1);
        check("R3 catch-up fire at", fire_at[0], 64'd135);
        check("R3 catch-up cmp", cmp_o, 64'd140);
    endtask

    task automatic t_masks();
        do_reset();
        wr(2'd0, 32'h2);
        wr(2'd2, 32'hFFFF_FFFF);
        check("R5 high period mask", period_o, 64'h7FFF_FFFF_0000_0000);
        check("R4 periodic cmp untouched", cmp_o, '1);
        wr(2'd0, 32'hA);
        check("R6 cmp truncated", cmp_o, 64'hFFFF_FFFF);
        check("R6 period truncated", period_o, 64'd0);
        wr(2'd1, 32'hFFFF_FFFF);
        check("R5 narrow period mask", period_o, 64'h7FFF_FFFF);
        wr(2'd2, 32'h1234);
        check("R6 high write ignored cmp", cmp_o, 64'hFFFF_FFFF);
        check("R6 high write ignored period", period_o, 64'h7FFF_FFFF);
    endtask

    task automatic t_wrap();
        do_reset();
        count_i = 64'h1_FFFF_FFF0;
        wr(2'd0, 32'h8);
        wr(2'd1, 32'h10);
        wr(2'd0, 32'h9);
        run_ticks(48);
        check("R7 wrap plus match fires", fires, 2);
        check("R7 wrap fire at", fire_at[0], 64'h2_0000_0000);
        check("R6 narrow match at", fire_at[1], 64'h2_0000_0010);
    endtask

    task automatic t_global();
        do_reset();
        global_en_i = 1'b0;
        count_i = 64'd390;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd400);
        wr(2'd0, 32'h1);
        run_ticks(20);
        check("R9 no fire while gated", fires, 0);
        global_en_i = 1'b1;
        run_ticks(1);
        check("R9 late fire count", fires, 1);
        check("R9 late fire at", fire_at[0], 64'd410);
    endtask

    task automatic t_disable();
        do_reset();
        count_i = 64'd490;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd500);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h0);
        run_ticks(20);
        check("R8 disabled no fire", fires, 0);
        wr(2'd0, 32'h1);
        run_ticks(1);
        check("R8 re-enable arms", fires, 1);
    endtask

    initial begin
        t_reset();
        t_oneshot();
        t_periodic();
        t_catchup();
        t_masks();
        t_wrap();
        t_global();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule